// File: doc/BRIEF.md
# Streaming 3x3 Window Generator

This block takes a raster stream of 8-bit grayscale pixels, one per clock while a valid strobe is high, and presents a 3x3 neighbourhood of them that moves one column to the right on every accepted pixel. It is the front end of a neighbourhood filter. A later stage reads the nine registered taps together with the window-valid flag and computes its own kernel.

Two circular row stores keep the two previous lines. Their depth is set at run time by an 11-bit line-length input, up to a compile-time maximum. A column counter and a saturating row counter track the raster position. A window is flagged valid only when it lies entirely inside stored data: at least two earlier lines have been received, and at least three pixels of the current line have arrived. Windows that would cross a line edge are never flagged, and no border padding is produced.

Top module: `win3x3_gen`

## Requirements
- R1: A synchronous active-low reset clears all nine taps, `valid_out` and every row-store entry. During the first line after reset, tap rows 0 and 1 therefore read zero.
- R2: The row stores act as delay lines of exactly `line_len` accepted pixels. After the column of pixel (line n, column c) is shifted in, tap (1,2) holds the pixel of line n-1 at column c. The value 0 on `line_len` stands for 2048.
- R3: The column index counts accepted pixels from 0 and wraps to 0 after `line_len`-1. The row count rises on each wrap and saturates at 2. No window is flagged while the column index is below 2.
- R4: Tap (r,k) sits at bits [(r*3+k)*8 +: 8] of `win_taps`. Row 0 is line n-2, row 2 is the live line, and column 2 is the newest. On each accepted pixel every row shifts one column toward column 0, and tap (2,2) takes the new pixel.
- R5: `valid_out` is high in the cycle after an accepted pixel exactly when that pixel had row count 2 and column index of at least 2. The first flag follows the (2*`line_len`+3)-th pixel after reset.
- R6: Whenever `valid_out` is high, tap (r,k) equals the pixel of line n-2+r at column c-2+k, where (n,c) is the position of the pixel just accepted.
- R7: A cycle with `valid_in` low changes no tap, counter or store, and `valid_out` is low in the following cycle.
- R8: For every line length from 3 up to the row-store maximum, each line past the second yields exactly `line_len`-2 flagged windows, one per accepted pixel from column 2 onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_len | input | 11 | Pixels per line (0 means 2048); held for the whole frame |
| valid_in | input | 1 | Marks `pixel_in` as a pixel to accept |
| pixel_in | input | 8 | Grayscale pixel, unsigned |
| win_taps | output | 72 | Nine registered 8-bit taps, tap (r,k) at bits [(r*3+k)*8 +: 8] |
| valid_out | output | 1 | The taps form a complete in-frame window |

## Verification
The column wrap and the row-count increment happen in the same cycle, on the last pixel of every line. The bench sweeps line lengths from 3 up to the store depth and checks, at each following pixel, that the flag drops at columns 0 and 1 and comes back at column 2. Idle cycles are inserted next to these wrap points in alternate frames. This shows that a stall does not move the counters or the taps around the boundary. Every flagged window is compared in full with a pixel pattern computed from its line and column.

// File: rtl/win3_pkg.sv
// Shared constants and helpers for the 3x3 window generator.
// Assumes a square window of side three; only the pixel width is free.
package win3_pkg;

    localparam int SIDE = 3;
    localparam int TAPS = SIDE * SIDE;

    // Flat position of tap (row, col) inside the packed tap vector.
    function automatic int tap_slot(input int row, input int col);
        return row * SIDE + col;
    endfunction

endpackage

// File: rtl/win3_line_store.sv
// Circular single-line delay store.
// One read and one write per accepted pixel at the same address: the read
// returns what was written one full line earlier. The effective length is
// set by how far the caller's address counter runs. Assumes the address
// stays below DEPTH.
module win3_line_store #(
    parameter int DEPTH = 640,
    parameter int PIX_W = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [PIX_W-1:0] din,
    output logic [PIX_W-1:0] dout
);

    logic [PIX_W-1:0] mem [DEPTH];

    // Old contents at the current column leave combinationally.
    assign dout = mem[addr];

    // Clear on reset, otherwise overwrite the current column on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[addr] <= din;
        end
    end

endmodule

// File: rtl/win3_raster_pos.sv
// Raster position tracker.
// Counts the column of each accepted pixel, wrapping after line_len-1.
// Counts completed lines up to a saturation value of two. Raises win_ok in
// the same cycle as an accepted pixel whose window lies entirely inside
// stored data. Assumes line_len is held steady for the frame.
module win3_raster_pos #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [LEN_W-1:0] line_len,
    output logic [LEN_W-1:0] col_idx,
    output logic [1:0]       row_cnt,
    output logic             win_ok
);

    localparam logic [1:0] ROW_FULL = 2'd2;

    logic [LEN_W-1:0] last_col;
    logic             at_last;

    // The modular subtraction maps a line length of 0 onto 2^LEN_W pixels.
    assign last_col = line_len - LEN_W'(1);
    assign at_last  = (col_idx == last_col);

    // Column counter: advance per accepted pixel, wrap at the line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_idx <= '0;
        end else if (accept) begin
            col_idx <= at_last ? '0 : col_idx + LEN_W'(1);
        end
    end

    // Line counter: bump on each wrap, hold once two lines are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_cnt <= '0;
        end else if (accept && at_last && (row_cnt != ROW_FULL)) begin
            row_cnt <= row_cnt + 2'd1;
        end
    end

    // Window qualifies when two prior lines exist and three columns are in.
    assign win_ok = accept && (row_cnt == ROW_FULL) && (col_idx >= LEN_W'(2));

endmodule

// File: rtl/win3_tap_array.sv
// 3x3 register array of window taps.
// Each row is a three-stage shift chain fed from its own column input.
// All rows shift together when shift_en is high and hold otherwise.
// Output is packed row-major, with column 2 the newest in each row.
module win3_tap_array
    import win3_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_en,
    input  logic [SIDE*PIX_W-1:0] col_in,
    output logic [TAPS*PIX_W-1:0] taps
);

    for (genvar r = 0; r < SIDE; r++) begin : g_row
        logic [PIX_W-1:0] stage [SIDE];

        // Shift this row one column toward index 0 on each accepted pixel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < SIDE; k++) begin
                    stage[k] <= '0;
                end
            end else if (shift_en) begin
                for (int k = 0; k < SIDE - 1; k++) begin
                    stage[k] <= stage[k+1];
                end
                stage[SIDE-1] <= col_in[r*PIX_W +: PIX_W];
            end
        end

        for (genvar k = 0; k < SIDE; k++) begin : g_col
            assign taps[tap_slot(r, k)*PIX_W +: PIX_W] = stage[k];
        end
    end

endmodule

// File: rtl/win3x3_gen.sv
// Streaming 3x3 window generator (top).
// Accepts one pixel per valid cycle and keeps two previous lines in
// circular row stores whose length follows line_len. It slides a 3x3 tap
// array one column per accepted pixel and flags windows that lie fully
// inside the frame. Assumes line_len <= MAX_LINE (line_len 0 means 2048)
// and that line_len is held steady for the whole frame.
module win3x3_gen
    import win3_pkg::*;
#(
    parameter int MAX_LINE = 640,
    parameter int PIX_W    = 8,
    parameter int LEN_W    = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LEN_W-1:0]      line_len,
    input  logic                  valid_in,
    input  logic [PIX_W-1:0]      pixel_in,
    output logic [TAPS*PIX_W-1:0] win_taps,
    output logic                  valid_out
);

    localparam int AW = (MAX_LINE > 1) ? $clog2(MAX_LINE) : 1;

    logic [LEN_W-1:0]      col_idx;
    logic [1:0]            row_cnt;
    logic                  win_ok;
    logic [AW-1:0]         rd_addr;
    logic [PIX_W-1:0]      prev_line;   // line n-1 at the current column
    logic [PIX_W-1:0]      prev2_line;  // line n-2 at the current column
    logic [SIDE*PIX_W-1:0] new_col;

    assign rd_addr = col_idx[AW-1:0];

    win3_raster_pos #(
        .LEN_W (LEN_W)
    ) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (valid_in),
        .line_len (line_len),
        .col_idx  (col_idx),
        .row_cnt  (row_cnt),
        .win_ok   (win_ok)
    );

    // First store delays the live stream by one line.
    win3_line_store #(
        .DEPTH (MAX_LINE),
        .PIX_W (PIX_W)
    ) u_store_near (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (valid_in),
        .addr  (rd_addr),
        .din   (pixel_in),
        .dout  (prev_line)
    );

    // Second store delays the first store's output by another line.
    win3_line_store #(
        .DEPTH (MAX_LINE),
        .PIX_W (PIX_W)
    ) u_store_far (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (valid_in),
        .addr  (rd_addr),
        .din   (prev_line),
        .dout  (prev2_line)
    );

    // Incoming column: oldest line in row 0, live pixel in row 2.
    assign new_col = {pixel_in, prev_line, prev2_line};

    win3_tap_array #(
        .PIX_W (PIX_W)
    ) u_taps (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (valid_in),
        .col_in   (new_col),
        .taps     (win_taps)
    );

    // Window flag registered alongside the taps it qualifies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
        end else begin
            valid_out <= win_ok;
        end
    end

endmodule

// File: rtl/win3_checker.sv
// Property checker for the 3x3 window generator, bound to the top module.
// Observes ports plus the raster counters.
module win3_checker #(
    parameter int PIX_W = 8,
    parameter int LEN_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LEN_W-1:0] line_len,
    input logic             valid_in,
    input logic [PIX_W-1:0] pixel_in,
    input logic [9*PIX_W-1:0] win_taps,
    input logic             valid_out,
    input logic [LEN_W-1:0] col_idx,
    input logic [1:0]       row_cnt
);

    logic seen_edge;

    // Marks that at least one clock edge has passed, so $past is meaningful.
    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        (seen_edge === 1'b1) && $past(!rst_n) |-> !valid_out && (win_taps == '0)); // R1

    AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in && (col_idx == line_len - LEN_W'(1)) |=> (col_idx == '0)); // R3

    AST_ROW_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        row_cnt <= 2'd2); // R3

    AST_NEWEST_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> (win_taps[8*PIX_W +: PIX_W] == $past(pixel_in))); // R4

    AST_ROW_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> (win_taps[0 +: 2*PIX_W] == $past(win_taps[PIX_W +: 2*PIX_W]))); // R4

    AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> $past(valid_in) && ($past(row_cnt) == 2'd2) && ($past(col_idx) >= LEN_W'(2))); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(win_taps) && $stable(col_idx) && !valid_out); // R7

endmodule

bind win3x3_gen win3_checker #(
    .PIX_W (PIX_W),
    .LEN_W (LEN_W)
) u_win3_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_len  (line_len),
    .valid_in  (valid_in),
    .pixel_in  (pixel_in),
    .win_taps  (win_taps),
    .valid_out (valid_out),
    .col_idx   (col_idx),
    .row_cnt   (row_cnt)
);

// File: tb/win3x3_gen_test.sv
`timescale 1ns/1ps
// Sweeps every line length from 3 to the store depth of a small build,
// with and without idle cycles, and checks each output against a computed
// pixel pattern.
module win3x3_gen_test;

    localparam int PW = 8;
    localparam int ML = 8;
    localparam int LW = 11;
    localparam int ROWS = 5;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [LW-1:0]   line_len;
    logic            valid_in;
    logic [PW-1:0]   pixel_in;
    logic [9*PW-1:0] win_taps;
    logic            valid_out;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    win3x3_gen #(
        .MAX_LINE (ML),
        .PIX_W    (PW),
        .LEN_W    (LW)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_len  (line_len),
        .valid_in  (valid_in),
        .pixel_in  (pixel_in),
        .win_taps  (win_taps),
        .valid_out (valid_out)
    );

    function automatic logic [PW-1:0] pv(int f, int r, int c);
        return PW'((f * 53 + r * 29 + c * 7 + 1) % 256);
    endfunction

    task automatic check(bit ok, string req, logic [9*PW-1:0] act, logic [9*PW-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_frame(int f, int len, bit gaps);
        logic [9*PW-1:0] exp;
        logic [9*PW-1:0] snap;
        int flagged = 0;
        @(negedge clk);
        rst_n = 1'b0; valid_in = 1'b0; pixel_in = '0; line_len = LW'(len);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(win_taps == '0 && !valid_out, "R1 reset state",
              {win_taps[9*PW-1:1], valid_out}, '0);
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < len; c++) begin
                valid_in = 1'b1;
                pixel_in = pv(f, r, c);
                @(posedge clk);
                @(negedge clk);
                valid_in = 1'b0;
                // R4: newest tap carries the pixel just accepted
                check(win_taps[8*PW +: PW] == pv(f, r, c), "R4 newest tap",
                      72'(win_taps[8*PW +: PW]), 72'(pv(f, r, c)));
                // R5 and R3: window flag from position
                if (r >= 2 && c < 2)
                    check(!valid_out, "R3 no flag at line edge", 72'(valid_out), 72'(0));
                else
                    check(valid_out == (r >= 2), "R5 window flag", 72'(valid_out), 72'(r >= 2));
                if (valid_out) flagged++;
                // R1: cleared stores show as zero rows during the first line
                if (r == 0)
                    check(win_taps[0 +: 6*PW] == '0, "R1 cleared stores",
                          72'(win_taps[0 +: 6*PW]), '0);
                // R2: second line sees the first line exactly one line back
                if (r == 1 && c >= 2) begin
                    exp = '0;
                    for (int k = 0; k < 3; k++) exp[(3 + k)*PW +: PW] = pv(f, 0, c - 2 + k);
                    check(win_taps[3*PW +: 3*PW] == exp[3*PW +: 3*PW], "R2 one-line delay",
                          72'(win_taps[3*PW +: 3*PW]), 72'(exp[3*PW +: 3*PW]));
                end
                // R6: full window content
                if (r >= 2 && c >= 2) begin
                    for (int i = 0; i < 3; i++)
                        for (int k = 0; k < 3; k++)
                            exp[(i*3 + k)*PW +: PW] = pv(f, r - 2 + i, c - 2 + k);
                    check(win_taps == exp, "R6 window content", win_taps, exp);
                end
                // R7: idle cycles near odd columns and line ends
                if (gaps && (c % 2 == 1 || c == len - 1)) begin
                    snap = win_taps;
                    @(posedge clk);
                    @(negedge clk);
                    check(win_taps == snap && !valid_out, "R7 idle hold",
                          {win_taps[9*PW-1:1], valid_out}, {snap[9*PW-1:1], 1'b0});
                end
            end
        end
        // R8: one flagged window per pixel from column 2 on every line past the second
        check(flagged == (ROWS - 2) * (len - 2), "R8 window count",
              72'(flagged), 72'((ROWS - 2) * (len - 2)));
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; valid_in = 1'b0; pixel_in = '0; line_len = LW'(3);
        for (int len = 3; len <= ML; len++) begin
            run_frame(len, len, 1'b0);
            run_frame(len + 10, len, 1'b1);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule